// File: doc/BRIEF.md
# Configurable I2C Target Address Matcher

This block sits behind the byte receiver of an I2C target and decides whether a freshly received address byte selects this target. The receiver presents the byte (seven address bits above a read/write bit) together with a one-cycle valid strobe. A primary address, a second configuration word and a two-bit mode select control how the second word is read: as a don't-care mask, as a second address, or as the lower bound of an inclusive address range.

One clock after the strobe, the block registers its decision and the direction bit, and holds both until the next strobe. A matching byte also produces a one-cycle match pulse. When automatic acknowledge is enabled, the block raises an acknowledge request for the acknowledge sequencer in the same cycle, so the address is acknowledged without waiting for a software command.

Top module: `tgt_addr_match`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, `match_pulse`, `hit`, `dir` and `ack_req` are all 0.
- R2: With `cfg_mode` = 0 (mask), a received address matches when every bit position where `cfg_aux` holds 0 equals the same bit of `cfg_addr`; a 1 in `cfg_aux` makes that bit a don't-care.
- R3: With `cfg_mode` = 1 (dual), a received address matches when it equals `cfg_addr` or equals `cfg_aux`.
- R4: With `cfg_mode` = 2 (range), a received address matches when `cfg_aux` <= address <= `cfg_addr` (unsigned). If `cfg_aux` > `cfg_addr`, nothing matches.
- R5: With `cfg_mode` = 3 (reserved), no address matches.
- R6: The decision is taken from the inputs sampled at the clock edge where `rx_valid` is 1 and appears on `hit` right after that edge. `match_pulse` is 1 for exactly that one cycle when the decision is a match, and 0 otherwise.
- R7: `dir` takes bit 0 of `rx_byte` (1 = read, 0 = write) at every strobe, whether or not the address matches.
- R8: `ack_req` is 1 in the same cycle as `match_pulse` when `auto_ack_en` was 1 at the strobe. It is 0 at all other times, including after a match with `auto_ack_en` = 0.
- R9: Between strobes, `hit` and `dir` hold their values, and changes to `cfg_addr`, `cfg_aux`, `cfg_mode` or `auto_ack_en` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: address byte is valid |
| rx_byte | input | ADDR_W+1 | Address in bits [ADDR_W:1], read/write bit in bit 0 |
| cfg_addr | input | ADDR_W | Primary address, which is also the upper range limit |
| cfg_aux | input | ADDR_W | Mask, second address, or lower range limit |
| cfg_mode | input | 2 | 0 mask, 1 dual, 2 range, 3 reserved |
| auto_ack_en | input | 1 | Automatic acknowledge enable |
| match_pulse | output | 1 | One-cycle pulse on an address match |
| hit | output | 1 | Held match decision of the last strobe |
| dir | output | 1 | Held read/write bit of the last strobe |
| ack_req | output | 1 | Auto-acknowledge request to the sequencer |

## Verification
The hardest cases to reach are the range-mode edges, where the lower bound equals the upper bound or lies above it, and changes to the configuration between two strobes. The bench places these inverted and degenerate ranges, an all-ones mask and an all-zeros mask among the configuration sets it sweeps across all 128 addresses in every mode. After each strobe, it scrambles every configuration input and the enable before checking that the held outputs have not moved.

// File: rtl/amatch_pkg.sv
package amatch_pkg;

   typedef enum logic [1:0] {
      AM_MASK  = 2'd0,
      AM_DUAL  = 2'd1,
      AM_RANGE = 2'd2,
      AM_RSVD  = 2'd3
   } am_mode_e;

endpackage

// File: rtl/amatch_decide.sv
module amatch_decide
   import amatch_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [ADDR_W-1:0] cfg_aux,
   input  am_mode_e          mode,
   output logic              hit_c
);

   logic [ADDR_W-1:0] bit_free;
   logic [ADDR_W-1:0] eq_pri;
   logic [ADDR_W-1:0] eq_sec;

   // per-bit comparators shared by mask and dual modes
   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      assign eq_pri[i]   = (rx_addr[i] == cfg_addr[i]);
      assign eq_sec[i]   = (rx_addr[i] == cfg_aux[i]);
      assign bit_free[i] = eq_pri[i] | cfg_aux[i];
   end

   logic mask_hit, dual_hit, range_hit;

   assign mask_hit  = &bit_free;
   assign dual_hit  = (&eq_pri) | (&eq_sec);
   assign range_hit = (rx_addr >= cfg_aux) && (rx_addr <= cfg_addr);

   always_comb begin
      unique case (mode)
         AM_MASK:  hit_c = mask_hit;
         AM_DUAL:  hit_c = dual_hit;
         AM_RANGE: hit_c = range_hit;
         default:  hit_c = 1'b0;
      endcase
   end

endmodule

// File: rtl/amatch_result.sv
module amatch_result (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic hit_c,
   input  logic dir_in,
   input  logic ack_en,
   output logic pulse,
   output logic hit_q,
   output logic dir_q,
   output logic ack_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse <= 1'b0;
         hit_q <= 1'b0;
         dir_q <= 1'b0;
         ack_q <= 1'b0;
      end else begin
         pulse <= strobe & hit_c;
         ack_q <= strobe & hit_c & ack_en;
         if (strobe) begin
            hit_q <= hit_c;
            dir_q <= dir_in;
         end
      end
   end

   assert_ack_has_match_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> pulse);

   assert_pulse_shows_hit_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> hit_q);

endmodule

// File: rtl/tgt_addr_match.sv
module tgt_addr_match
   import amatch_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [ADDR_W:0]   rx_byte,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [ADDR_W-1:0] cfg_aux,
   input  logic [1:0]        cfg_mode,
   input  logic              auto_ack_en,
   output logic              match_pulse,
   output logic              hit,
   output logic              dir,
   output logic              ack_req
);

   localparam int BYTE_W = ADDR_W + 1;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_width
      $error("tgt_addr_match: ADDR_W must lie in 1..10");
   end

   logic [ADDR_W-1:0] rx_addr;
   logic              rx_rw;
   logic              hit_c;

   assign rx_addr = rx_byte[BYTE_W-1:1];
   assign rx_rw   = rx_byte[0];

   amatch_decide #(.ADDR_W(ADDR_W)) u_decide (
      .rx_addr  (rx_addr),
      .cfg_addr (cfg_addr),
      .cfg_aux  (cfg_aux),
      .mode     (am_mode_e'(cfg_mode)),
      .hit_c    (hit_c)
   );

   amatch_result u_result (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (rx_valid),
      .hit_c  (hit_c),
      .dir_in (rx_rw),
      .ack_en (auto_ack_en),
      .pulse  (match_pulse),
      .hit_q  (hit),
      .dir_q  (dir),
      .ack_q  (ack_req)
   );

   assert_pulse_after_strobe_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> $past(rx_valid));

   assert_hold_between_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> ($stable(hit) && $stable(dir) && !match_pulse && !ack_req));

   assert_dir_follows_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> (dir == $past(rx_rw)));

   assert_reserved_quiet_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_mode == 2'd3) |=> !hit);

   assert_empty_range_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_mode == 2'd2 && cfg_aux > cfg_addr) |=> !hit);

   assert_no_ack_disabled_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !auto_ack_en) |=> !ack_req);

endmodule

// File: tb/sim_tgt_addr_match.sv
`timescale 1ns/1ps
module sim_tgt_addr_match;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic [6:0] cfg_addr = '0;
   logic [6:0] cfg_aux = '0;
   logic [1:0] cfg_mode = '0;
   logic       auto_ack_en = 1'b0;
   logic       match_pulse, hit, dir, ack_req;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tgt_addr_match #(.ADDR_W(7)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .cfg_addr(cfg_addr), .cfg_aux(cfg_aux), .cfg_mode(cfg_mode),
      .auto_ack_en(auto_ack_en), .match_pulse(match_pulse), .hit(hit),
      .dir(dir), .ack_req(ack_req)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (mode=%0d addr=%0h aux=%0h)",
                  req, act, exp, cfg_mode, cfg_addr, cfg_aux);
      end
   endtask

   function automatic bit ref_hit(input int m, input int a, input int p, input int x);
      case (m)
         0: ref_hit = (((a ^ p) & ~x) & 8'h7F) == 0;
         1: ref_hit = (a == p) || (a == x);
         2: ref_hit = (a >= x) && (a <= p);
         default: ref_hit = 1'b0;
      endcase
   endfunction

   task automatic one(input int m, input int p, input int x, input int a, input bit rw, input bit aen);
      bit e;
      bit held_hit, held_dir;
      e = ref_hit(m, a, p, x);
      cfg_mode = 2'(m); cfg_addr = 7'(p); cfg_aux = 7'(x); auto_ack_en = aen;
      rx_byte = {7'(a), rw}; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      case (m)
         0: chk("R2", hit, e);
         1: chk("R3", hit, e);
         2: chk("R4", hit, e);
         default: chk("R5", hit, 0);
      endcase
      chk("R6", match_pulse, e);
      chk("R7", dir, rw);
      chk("R8", ack_req, e & aen);
      held_hit = hit; held_dir = dir;
      // scramble configuration between strobes
      cfg_mode = 2'($urandom); cfg_addr = 7'($urandom); cfg_aux = 7'($urandom);
      auto_ack_en = ~aen; rx_byte = 8'($urandom);
      @(negedge clk);
      chk("R9", hit, held_hit);
      chk("R9", dir, held_dir);
      chk("R6", match_pulse, 0);
      chk("R9", ack_req, 0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234));
      repeat (3) @(negedge clk);
      chk("R1", {match_pulse, hit, dir, ack_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {match_pulse, hit, dir, ack_req}, 0);
      for (int c = 0; c < 8; c++) begin
         int p, x;
         case (c)
            0: begin p = 'h50; x = 'h0F; end
            1: begin p = 'h2A; x = 'h7F; end
            2: begin p = 'h10; x = 'h20; end
            3: begin p = 'h33; x = 'h33; end
            4: begin p = 'h7F; x = 'h00; end
            default: begin p = int'($urandom & 8'h7F); x = int'($urandom & 8'h7F); end
         endcase
         for (int m = 0; m < 4; m++)
            for (int a = 0; a < 128; a++)
               one(m, p, x, a, bit'((a >> 1) ^ c), bit'(a ^ m));
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule